// File: doc/BRIEF.md
# MDIO Management Target

This block is the device end of a two-wire management bus. A faster system clock oversamples the serial clock and data lines. The block waits for a long run of ones followed by a valid start marker, then decodes a read or write command that carries a 5-bit device address and a 5-bit register index. A command is acted on only when the device address equals the strapped address on `dev_addr`. Frames addressed to other devices are followed to their end, and the block never drives the line for them.

A matching write delivers 16 bits into a local bank of 32 sixteen-bit entries. A matching read takes over the line at the second turnaround bit and shifts the addressed entry out, most significant bit first. Two entries hold fixed identifier words. A combinational read port lets surrounding logic see any entry, and a one-cycle strobe reports each committed write.

Top module: `mdio_target`

## Requirements
- R1: After reset, `mdio_oe` is 0, `mdio_do` is 1 and `wr_stb` is 0. Entries 0, 1 and 4 to 31 read 0. Entry 2 reads 16'h0141 and entry 3 reads 16'h0C2A.
- R2: A write frame has at least 32 ones, then start 0,1, then opcode 0,1, then the device address and register index (both MSB first), then turnaround, then 16 data bits MSB first. When its address matches and its index is not 2 or 3, the entry takes the data. `wr_stb` is then high for exactly one cycle, with `wr_idx` and `wr_data` giving the index and the value.
- R3: A read frame uses opcode 1,0. When its address matches, the line reads 0 during the second turnaround bit. The 16 bits of the addressed entry then follow, MSB first, each valid while MDC is high.
- R4: `mdio_oe` is 0 during the first turnaround bit of a read and is 0 again once the last data bit has ended. `mdio_do` is 1 whenever `mdio_oe` is 0. `mdio_oe` changes only in the cycle after a detected MDC falling edge.
- R5: A frame whose device address differs from `dev_addr` never raises `mdio_oe` and never changes an entry or raises `wr_stb`.
- R6: A frame with fewer than 32 ones before the start marker is ignored: no strobe and no line drive.
- R7: A frame whose opcode is 0,0 or 1,1 is ignored.
- R8: A frame whose start marker is not 0,1 is ignored.
- R9: Writes to entries 2 and 3 leave them unchanged and raise no strobe.
- R10: `loc_data` shows the entry selected by `loc_idx` in the same cycle.
- R11: After a frame ends or is dropped, the block hunts for a new preamble, and the next valid frame is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_addr | input | 5 | Strapped device address |
| mdc_in | input | 1 | Management clock from the bus master |
| mdio_in | input | 1 | Management data line as seen at the pin |
| mdio_oe | output | 1 | Drive enable for the data line |
| mdio_do | output | 1 | Value driven when `mdio_oe` is 1 |
| loc_idx | input | 5 | Local read index |
| loc_data | output | 16 | Entry selected by `loc_idx` |
| wr_stb | output | 1 | One-cycle pulse for a committed write |
| wr_idx | output | 5 | Index of the committed write |
| wr_data | output | 16 | Value of the committed write |

## Verification
The assertions assume that MDC stays at each level for several system-clock cycles, so a rising edge and a falling edge are never detected together. They also assume that two committed writes are at least one MDC period apart. The stimulus holds every MDC level for eight system cycles and changes the data line only while MDC is low. The bench releases the line for the whole turnaround and data phase of every read, so the target's drive never collides with the master's.

// File: rtl/mdio_tgt_pkg.sv
package mdio_tgt_pkg;

  // Frame decode phases, in bus order
  typedef enum logic [2:0] {
    S_HUNT,
    S_START,
    S_OP,
    S_ADDR,
    S_TA,
    S_DATA
  } fr_state_e;

endpackage

// File: rtl/mdio_rx_sync.sv
module mdio_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc_in,
  input  logic mdio_in,
  output logic rx_bit,
  output logic mdc_rise,
  output logic mdc_fall
);

  // One extra MDC stage keeps the previous synchronized level
  logic [STAGES:0]   mdc_q;
  logic [STAGES-1:0] dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_q <= '0;
      dat_q <= '1;
    end else begin
      mdc_q <= {mdc_q[STAGES-1:0], mdc_in};
      dat_q <= {dat_q[STAGES-2:0], mdio_in};
    end
  end

  assign rx_bit   = dat_q[STAGES-1];
  assign mdc_rise =  mdc_q[STAGES-1] & ~mdc_q[STAGES];
  assign mdc_fall = ~mdc_q[STAGES-1] &  mdc_q[STAGES];

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
  import mdio_tgt_pkg::*;
#(
  parameter int PHY_W   = 5,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHY_W-1:0]  dev_addr,
  input  logic              rx_bit,
  input  logic              mdc_rise,
  input  logic              mdc_fall,
  input  logic [DATA_W-1:0] rd_data,
  output logic [REG_W-1:0]  reg_idx,
  output logic              wr_req,
  output logic [DATA_W-1:0] wr_data,
  output logic              mdio_oe,
  output logic              mdio_do,
  output logic              rd_match
);

  localparam int HDR_W = PHY_W + REG_W;
  localparam int PC_W  = $clog2(PRE_LEN + 1);
  localparam int MAXB  = (DATA_W > HDR_W) ? DATA_W : HDR_W;
  localparam int BC_W  = $clog2(MAXB);

  fr_state_e         state_q, state_d;
  logic [PC_W-1:0]   ones_q, ones_d;
  logic [BC_W-1:0]   bcnt_q, bcnt_d;
  logic [HDR_W-1:0]  hdr_q, hdr_d, hdr_sh;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              rd_q, rd_d;
  logic              hit_q, hit_d;
  logic              oe_q, oe_d;
  logic              do_q, do_d;
  logic              wrq_q, wrq_d;

  assign hdr_sh = {hdr_q[HDR_W-2:0], rx_bit};

  // Next-state logic: inputs are taken on MDC rising edges
  // and the driven value is updated on MDC falling edges
  always_comb begin
    state_d = state_q;
    ones_d  = ones_q;
    bcnt_d  = bcnt_q;
    hdr_d   = hdr_q;
    sh_d    = sh_q;
    rd_d    = rd_q;
    hit_d   = hit_q;
    oe_d    = oe_q;
    do_d    = do_q;
    wrq_d   = 1'b0;

    if (mdc_rise) begin
      case (state_q)
        S_HUNT: begin
          if (rx_bit) begin
            if (ones_q != PC_W'(PRE_LEN)) ones_d = ones_q + 1'b1;
          end else begin
            if (ones_q == PC_W'(PRE_LEN)) state_d = S_START;
            ones_d = '0;
          end
        end
        S_START: begin
          bcnt_d  = '0;
          state_d = rx_bit ? S_OP : S_HUNT;
        end
        S_OP: begin
          if (bcnt_q == '0) begin
            rd_d   = rx_bit;
            bcnt_d = BC_W'(1);
          end else begin
            bcnt_d  = '0;
            // valid opcodes are the two patterns whose bits differ
            state_d = (rd_q != rx_bit) ? S_ADDR : S_HUNT;
          end
        end
        S_ADDR: begin
          hdr_d = hdr_sh;
          if (bcnt_q == BC_W'(HDR_W - 1)) begin
            bcnt_d  = '0;
            state_d = S_TA;
            hit_d   = (hdr_sh[HDR_W-1:REG_W] == dev_addr);
          end else begin
            bcnt_d = bcnt_q + 1'b1;
          end
        end
        S_TA: begin
          if (bcnt_q == '0) begin
            bcnt_d = BC_W'(1);
          end else begin
            bcnt_d  = '0;
            state_d = S_DATA;
            sh_d    = rd_data;
          end
        end
        S_DATA: begin
          if (!rd_q) sh_d = {sh_q[DATA_W-2:0], rx_bit};
          if (bcnt_q == BC_W'(DATA_W - 1)) begin
            bcnt_d  = '0;
            state_d = S_HUNT;
            wrq_d   = !rd_q && hit_q;
          end else begin
            bcnt_d = bcnt_q + 1'b1;
          end
        end
        default: state_d = S_HUNT;
      endcase
    end

    if (mdc_fall) begin
      oe_d = 1'b0;
      do_d = 1'b1;
      if (rd_q && hit_q) begin
        if (state_q == S_TA && bcnt_q == BC_W'(1)) begin
          oe_d = 1'b1;
          do_d = 1'b0;
        end else if (state_q == S_DATA) begin
          oe_d = 1'b1;
          do_d = sh_q[DATA_W-1];
          sh_d = {sh_q[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_HUNT;
      ones_q  <= '0;
      bcnt_q  <= '0;
      hdr_q   <= '0;
      sh_q    <= '0;
      rd_q    <= 1'b0;
      hit_q   <= 1'b0;
      oe_q    <= 1'b0;
      do_q    <= 1'b1;
      wrq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ones_q  <= ones_d;
      bcnt_q  <= bcnt_d;
      hdr_q   <= hdr_d;
      sh_q    <= sh_d;
      rd_q    <= rd_d;
      hit_q   <= hit_d;
      oe_q    <= oe_d;
      do_q    <= do_d;
      wrq_q   <= wrq_d;
    end
  end

  assign reg_idx  = hdr_q[REG_W-1:0];
  assign wr_req   = wrq_q;
  assign wr_data  = sh_q;
  assign mdio_oe  = oe_q;
  assign mdio_do  = do_q;
  assign rd_match = rd_q & hit_q;

endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile #(
  parameter int              NREG   = 32,
  parameter int              DATA_W = 16,
  parameter int              IDX_W  = 5,
  parameter int              RO_A   = 2,
  parameter int              RO_B   = 3,
  parameter logic [DATA_W-1:0] ID_HI = 16'h0141,
  parameter logic [DATA_W-1:0] ID_LO = 16'h0C2A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rda_idx,
  output logic [DATA_W-1:0] rda_data,
  input  logic [IDX_W-1:0]  rdb_idx,
  output logic [DATA_W-1:0] rdb_data,
  output logic              stb,
  output logic [IDX_W-1:0]  stb_idx,
  output logic [DATA_W-1:0] stb_data
);

  logic [DATA_W-1:0] ent [NREG];
  logic              wr_ok;

  assign wr_ok = wr_req && (wr_idx != IDX_W'(RO_A)) && (wr_idx != IDX_W'(RO_B));

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    if (g == RO_A) begin : g_id_hi
      assign ent[g] = ID_HI;
    end else if (g == RO_B) begin : g_id_lo
      assign ent[g] = ID_LO;
    end else begin : g_rw
      logic [DATA_W-1:0] val_q;
      logic              en;
      assign en = wr_ok && (wr_idx == IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  val_q <= '0;
        else if (en) val_q <= wr_data;
      end
      assign ent[g] = val_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb      <= 1'b0;
      stb_idx  <= '0;
      stb_data <= '0;
    end else begin
      stb <= wr_ok;
      if (wr_ok) begin
        stb_idx  <= wr_idx;
        stb_data <= wr_data;
      end
    end
  end

  assign rda_data = ent[rda_idx];
  assign rdb_data = ent[rdb_idx];

endmodule

// File: rtl/mdio_target.sv
module mdio_target #(
  parameter int                PHY_W       = 5,
  parameter int                REG_W       = 5,
  parameter int                DATA_W      = 16,
  parameter int                PRE_LEN     = 32,
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] ID_HI       = 16'h0141,
  parameter logic [DATA_W-1:0] ID_LO       = 16'h0C2A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHY_W-1:0]  dev_addr,
  input  logic              mdc_in,
  input  logic              mdio_in,
  output logic              mdio_oe,
  output logic              mdio_do,
  input  logic [REG_W-1:0]  loc_idx,
  output logic [DATA_W-1:0] loc_data,
  output logic              wr_stb,
  output logic [REG_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data
);

  localparam int NREG = 1 << REG_W;

  logic [1:0]        rst_sq;
  logic              rst_ni;
  logic              rx_bit_w, rise_w, fall_w;
  logic [REG_W-1:0]  reg_idx_w;
  logic              wr_req_w, rd_match_w;
  logic [DATA_W-1:0] fsm_wdata_w, rd_data_w;

  // Reset asserts at once and is released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= 2'b00;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_ni = rst_sq[1];

  mdio_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_ni),
    .mdc_in   (mdc_in),
    .mdio_in  (mdio_in),
    .rx_bit   (rx_bit_w),
    .mdc_rise (rise_w),
    .mdc_fall (fall_w)
  );

  mdio_frame_fsm #(
    .PHY_W  (PHY_W),
    .REG_W  (REG_W),
    .DATA_W (DATA_W),
    .PRE_LEN(PRE_LEN)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_ni),
    .dev_addr (dev_addr),
    .rx_bit   (rx_bit_w),
    .mdc_rise (rise_w),
    .mdc_fall (fall_w),
    .rd_data  (rd_data_w),
    .reg_idx  (reg_idx_w),
    .wr_req   (wr_req_w),
    .wr_data  (fsm_wdata_w),
    .mdio_oe  (mdio_oe),
    .mdio_do  (mdio_do),
    .rd_match (rd_match_w)
  );

  mdio_regfile #(
    .NREG  (NREG),
    .DATA_W(DATA_W),
    .IDX_W (REG_W),
    .RO_A  (2),
    .RO_B  (3),
    .ID_HI (ID_HI),
    .ID_LO (ID_LO)
  ) u_rf (
    .clk      (clk),
    .rst_n    (rst_ni),
    .wr_req   (wr_req_w),
    .wr_idx   (reg_idx_w),
    .wr_data  (fsm_wdata_w),
    .rda_idx  (reg_idx_w),
    .rda_data (rd_data_w),
    .rdb_idx  (loc_idx),
    .rdb_data (loc_data),
    .stb      (wr_stb),
    .stb_idx  (wr_idx),
    .stb_data (wr_data)
  );

endmodule

// File: rtl/mdio_target_chk.sv
module mdio_target_chk #(
  parameter int IDX_W = 5,
  parameter int RO_A  = 2,
  parameter int RO_B  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mdio_oe,
  input logic             mdio_do,
  input logic             mdc_fall,
  input logic             rd_match,
  input logic             wr_stb,
  input logic [IDX_W-1:0] wr_idx
);

  // R4: the drive enable moves only right after a detected falling edge
  a_r4_oe_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_oe) |-> $past(mdc_fall));

  // R4: a released line is always paired with a high data value
  a_r4_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !mdio_oe |-> mdio_do);

  // R5: driving needs a decoded read to this device
  a_r5_drive_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> rd_match);

  // R2: the commit strobe lasts one cycle
  a_r2_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R9: no strobe ever names an identifier entry
  a_r9_no_ro_stb: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (wr_idx != IDX_W'(RO_A) && wr_idx != IDX_W'(RO_B)));

endmodule

bind mdio_target mdio_target_chk #(.IDX_W(REG_W), .RO_A(2), .RO_B(3)) u_chk (
  .clk      (clk),
  .rst_n    (rst_ni),
  .mdio_oe  (mdio_oe),
  .mdio_do  (mdio_do),
  .mdc_fall (fall_w),
  .rd_match (rd_match_w),
  .wr_stb   (wr_stb),
  .wr_idx   (wr_idx)
);

// File: tb/sim_mdio_target.sv
module sim_mdio_target;

  localparam logic [4:0]  DEV   = 5'h0B;
  localparam logic [15:0] K_HI  = 16'h0141;
  localparam logic [15:0] K_LO  = 16'h0C2A;
  localparam int          NV    = 18;

  typedef struct packed {
    logic [5:0]  pre;
    logic [1:0]  st;
    logic [1:0]  op;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] dat;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{6'd32, 2'b01, 2'b01, 5'h0B, 5'd5,  16'hA5C3},
    '{6'd32, 2'b01, 2'b10, 5'h0B, 5'd5,  16'h0000},
    '{6'd32, 2'b01, 2'b01, 5'h0B, 5'd31, 16'h1234},
    '{6'd32, 2'b01, 2'b01, 5'h0C, 5'd5,  16'hFFFF},
    '{6'd32, 2'b01, 2'b10, 5'h0B, 5'd5,  16'h0000},
    '{6'd32, 2'b01, 2'b01, 5'h0B, 5'd2,  16'hDEAD},
    '{6'd32, 2'b01, 2'b10, 5'h0B, 5'd2,  16'h0000},
    '{6'd32, 2'b01, 2'b10, 5'h0B, 5'd3,  16'h0000},
    '{6'd31, 2'b01, 2'b01, 5'h0B, 5'd7,  16'h5555},
    '{6'd32, 2'b01, 2'b10, 5'h0B, 5'd7,  16'h0000},
    '{6'd32, 2'b01, 2'b11, 5'h0B, 5'd7,  16'h0F0F},
    '{6'd32, 2'b01, 2'b00, 5'h0B, 5'd7,  16'h0F0F},
    '{6'd32, 2'b00, 2'b01, 5'h0B, 5'd7,  16'h0F0F},
    '{6'd32, 2'b01, 2'b10, 5'h0B, 5'd7,  16'h0000},
    '{6'd32, 2'b01, 2'b10, 5'h1F, 5'd5,  16'h0000},
    '{6'd32, 2'b01, 2'b01, 5'h0B, 5'd0,  16'h8001},
    '{6'd32, 2'b01, 2'b10, 5'h0B, 5'd0,  16'h0000},
    '{6'd32, 2'b01, 2'b10, 5'h0B, 5'd31, 16'h0000}
  };

  logic        clk, rst_n;
  logic        mdc, drv_en, drv_val, line;
  logic        mdio_oe, mdio_do, wr_stb;
  logic [4:0]  loc_idx, wr_idx;
  logic [15:0] loc_data, wr_data;
  logic [15:0] model [32];
  int          checks, errors;
  int          stb_cnt, oe_cnt;
  logic [4:0]  last_idx;
  logic [15:0] last_dat;

  assign line = drv_en ? drv_val : (mdio_oe ? mdio_do : 1'b1);

  mdio_target u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .dev_addr (DEV),
    .mdc_in   (mdc),
    .mdio_in  (line),
    .mdio_oe  (mdio_oe),
    .mdio_do  (mdio_do),
    .loc_idx  (loc_idx),
    .loc_data (loc_data),
    .wr_stb   (wr_stb),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (wr_stb) begin
      stb_cnt  <= stb_cnt + 1;
      last_idx <= wr_idx;
      last_dat <= wr_data;
    end
    if (mdio_oe) oe_cnt <= oe_cnt + 1;
  end

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // One MDC period: data set while low, sampled in the high phase
  task automatic mbit(input logic en, input logic val,
                      output logic smp, output logic oe_s);
    drv_en  = en;
    drv_val = val;
    repeat (8) @(negedge clk);
    mdc = 1'b1;
    repeat (4) @(negedge clk);
    smp  = line;
    oe_s = mdio_oe;
    repeat (4) @(negedge clk);
    mdc = 1'b0;
  endtask

  task automatic run_frame(input vec_t v, output logic ta1_oe,
                           output logic ta2_line, output logic [15:0] rdv);
    logic s, o;
    bit   rel;
    rel = (v.op == 2'b10) && (v.st == 2'b01) && (v.pre >= 6'd32);
    ta1_oe = 1'b0; ta2_line = 1'b1; rdv = '0;
    for (int i = 0; i < int'(v.pre); i++) mbit(1'b1, 1'b1, s, o);
    mbit(1'b1, v.st[1], s, o);
    mbit(1'b1, v.st[0], s, o);
    mbit(1'b1, v.op[1], s, o);
    mbit(1'b1, v.op[0], s, o);
    for (int i = 4; i >= 0; i--) mbit(1'b1, v.phy[i], s, o);
    for (int i = 4; i >= 0; i--) mbit(1'b1, v.rg[i], s, o);
    if (rel) begin
      mbit(1'b0, 1'b1, s, o); ta1_oe = o;
      mbit(1'b0, 1'b1, s, o); ta2_line = s;
      for (int i = 0; i < 16; i++) begin
        mbit(1'b0, 1'b1, s, o);
        rdv = {rdv[14:0], s};
      end
    end else begin
      mbit(1'b1, 1'b1, s, o);
      mbit(1'b1, 1'b0, s, o);
      for (int i = 15; i >= 0; i--) mbit(1'b1, v.dat[i], s, o);
    end
    drv_en = 1'b0;
    repeat (24) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    vec_t        v;
    logic        t1, t2;
    logic [15:0] rv;
    int          s0, o0;
    bit          valid, hit, isrd;
    checks = 0; errors = 0; stb_cnt = 0; oe_cnt = 0;
    last_idx = '0; last_dat = '0;
    mdc = 1'b0; drv_en = 1'b0; drv_val = 1'b1; loc_idx = '0;
    for (int i = 0; i < 32; i++) model[i] = 16'h0000;
    model[2] = K_HI;
    model[3] = K_LO;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: state after reset
    chk(mdio_oe == 1'b0, "R1 oe", 32'(mdio_oe), 32'd0);
    chk(mdio_do == 1'b1, "R1 do", 32'(mdio_do), 32'd1);
    chk(wr_stb == 1'b0, "R1 stb", 32'(wr_stb), 32'd0);
    loc_idx = 5'd0; @(negedge clk);
    chk(loc_data == 16'h0000, "R1 entry0", 32'(loc_data), 32'h0);
    loc_idx = 5'd2; @(negedge clk);
    chk(loc_data == K_HI, "R1 entry2", 32'(loc_data), 32'(K_HI));
    loc_idx = 5'd3; @(negedge clk);
    chk(loc_data == K_LO, "R1 entry3", 32'(loc_data), 32'(K_LO));

    for (int k = 0; k < NV; k++) begin
      v  = VEC[k];
      s0 = stb_cnt;
      o0 = oe_cnt;
      run_frame(v, t1, t2, rv);
      valid = (v.pre >= 6'd32) && (v.st == 2'b01) && (v.op == 2'b10 || v.op == 2'b01);
      hit   = (v.phy == DEV);
      isrd  = (v.op == 2'b10);
      if (valid && hit && !isrd) begin
        if (v.rg == 5'd2 || v.rg == 5'd3) begin
          chk(stb_cnt == s0, "R9 strobe", 32'(stb_cnt - s0), 32'd0);
        end else begin
          chk(stb_cnt == s0 + 1, "R2 strobe count", 32'(stb_cnt - s0), 32'd1);
          chk(last_idx == v.rg && last_dat == v.dat, "R2 strobe fields",
              {11'd0, last_idx, last_dat}, {11'd0, v.rg, v.dat});
          model[v.rg] = v.dat;
        end
      end else if (valid && hit) begin
        chk(t1 == 1'b0, "R4 first turnaround bit", 32'(t1), 32'd0);
        chk(t2 == 1'b0, "R3 second turnaround bit", 32'(t2), 32'd0);
        chk(rv == model[v.rg], "R3/R11 read data", 32'(rv), 32'(model[v.rg]));
      end else if (!valid) begin
        chk(stb_cnt == s0 && oe_cnt == o0,
            (v.pre < 6'd32) ? "R6 short preamble" :
            (v.st != 2'b01) ? "R8 bad start" : "R7 bad opcode",
            32'((stb_cnt - s0) + (oe_cnt - o0)), 32'd0);
      end else begin
        chk(stb_cnt == s0 && oe_cnt == o0, "R5 other address",
            32'((stb_cnt - s0) + (oe_cnt - o0)), 32'd0);
      end
      chk(mdio_oe == 1'b0, "R4 released after frame", 32'(mdio_oe), 32'd0);
      loc_idx = v.rg;
      @(negedge clk);
      chk(loc_data == model[v.rg], "R10 local read", 32'(loc_data), 32'(model[v.rg]));
    end

    // R10: sweep of every entry against the model
    for (int i = 0; i < 32; i++) begin
      loc_idx = 5'(i);
      @(negedge clk);
      chk(loc_data == model[i], "R10 sweep", 32'(loc_data), 32'(model[i]));
    end

    summary();
  end

endmodule